// File: doc/BRIEF.md
# Memory Access Splitter

This block sits between a requester and the protection-check and memory path. It accepts one memory request at a time. A request carries a start address, a power-of-two byte size, an access kind (load, store, instruction fetch or cache-block zero) and a privilege level. The block cuts the request into parts at aligned granule boundaries. It presents the parts one after another, with rising addresses, on a valid/ready port that feeds the checker and memory. The checker answers each part with a pass/fail flag that is valid on the same handshake.

The granule is the native word for loads, stores and fetches. For a block-zero request, a configuration pin picks between two options: 32-byte parts, or one operation that covers the whole block. Because each part is checked on its own, the result can depend on the split. A part that passed is already committed to memory and is never undone. Issuing stops at the first part that fails. A single response then reports an access fault, its cause class and the start address of the failing part.

Top module: `access_splitter`

## Requirements
- R1: While reset is asserted, and after it is released, `req_ready` is 1 and both `sub_valid` and `rsp_valid` are 0.
- R2: A load, store or fetch is issued as the parts it forms with each aligned WORD_BYTES granule. The parts are non-empty and contiguous, start at the request address and go in ascending order. One part is consumed per `sub_valid`/`sub_ready` handshake.
- R3: An aligned access wider than a word, such as an 8-byte store at a multiple of 8, is still issued as word-sized parts.
- R4: `req_kind` codes are 0 load, 1 store, 2 fetch and 3 block zero. A block zero is cut into BLOCK_BYTES parts when `cfg_bzero_split` is 1 at acceptance. It is issued as one part of the full size when that pin is 0.
- R5: While `sub_valid` is 1 and `sub_ready` is 0, the offered part (`sub_addr`, `sub_bytes`) stays unchanged.
- R6: When a part is handshaken with `sub_fail` 1, no further part is issued. In the next cycle `rsp_valid` is 1 with `rsp_fault` 1 and `rsp_fault_addr` equal to that part's start address.
- R7: `rsp_cause` is 0 for a fetch fault, 1 for a load fault and 2 for a store or block-zero fault.
- R8: If every part passes, the response carries `rsp_fault` 0 and `rsp_fault_addr` 0.
- R9: Parts that pass before a failure are each handshaken exactly once, and none is reissued.
- R10: From acceptance until the response is taken, `req_ready` is 0. A `req_valid` raised in that window has no effect on the parts or on the response.
- R11: The response is held stable until `rsp_ready` is 1. In the cycle after that handshake, `rsp_valid` is 0 and `req_ready` is 1.
- R12: Every part carries the request's kind on `sub_kind` and its privilege on `sub_priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bzero_split | input | 1 | 1: block zero in BLOCK_BYTES parts; 0: one operation |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on handshake |
| req_addr | input | ADDR_W | Request start byte address |
| req_size_lg2 | input | LG_W | log2 of request byte count (0..MAX_LG) |
| req_kind | input | 2 | Access kind code |
| req_priv | input | 2 | Privilege level, passed through |
| sub_valid | output | 1 | Part offered to checker and memory |
| sub_ready | input | 1 | Part consumed |
| sub_addr | output | ADDR_W | Part start address |
| sub_bytes | output | CNT_W | Part byte count |
| sub_kind | output | 2 | Access kind of the part |
| sub_priv | output | 2 | Privilege of the part |
| sub_fail | input | 1 | Check verdict, valid on part handshake |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_fault | output | 1 | Access fault |
| rsp_cause | output | 2 | Fault class |
| rsp_fault_addr | output | ADDR_W | Start address of the failing part |

## Verification
The bench builds the block with its defaults: a 32-bit address, 4-byte words, 32-byte block parts and sizes up to 64 bytes. With these values, one request can cross a word boundary, an 8-byte store produces two or three parts, and a 64-byte block zero can be issued either as two halves or as one operation. A checker model in the bench fails any part that crosses a 32-byte region or touches a denied byte range. This exercises the split-dependent outcome, a fault in the middle of a store, and faults on the first and the last part.

// File: rtl/asplit_pkg.sv
package asplit_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_BZERO = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_INSTR = 2'd0,
    CAUSE_LOAD  = 2'd1,
    CAUSE_STORE = 2'd2
  } fault_cause_e;

  typedef enum logic [1:0] {
    GRAN_WORD  = 2'd0,
    GRAN_BLOCK = 2'd1,
    GRAN_WHOLE = 2'd2
  } gran_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } seq_state_e;

  function automatic fault_cause_e cause_of(acc_kind_e k);
    case (k)
      KIND_FETCH: return CAUSE_INSTR;
      KIND_LOAD:  return CAUSE_LOAD;
      default:    return CAUSE_STORE;
    endcase
  endfunction

endpackage

// File: rtl/asplit_piece.sv
module asplit_piece
  import asplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 32,
  parameter int CNT_W       = 7
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W:0]   end_addr,
  input  gran_e             gran,
  output logic [CNT_W-1:0]  piece_bytes,
  output logic [ADDR_W:0]   piece_next,
  output logic              piece_last
);

  localparam int NGRAN   = 2;
  localparam int WORD_LG = $clog2(WORD_BYTES);
  localparam int BLK_LG  = $clog2(BLOCK_BYTES);
  localparam logic [ADDR_W:0] ONE = 1;

  logic [ADDR_W:0] cur_ext;
  logic [ADDR_W:0] bound [NGRAN];
  logic [ADDR_W:0] lim;
  logic [ADDR_W:0] span;
  logic            unused_span_hi;

  assign cur_ext = {1'b0, cur_addr};

  // next aligned boundary above the current address, one per granule option
  generate
    for (genvar g = 0; g < NGRAN; g++) begin : g_bound
      localparam int LG = (g == 0) ? WORD_LG : BLK_LG;
      assign bound[g] = ((cur_ext >> LG) + ONE) << LG;
    end
  endgenerate

  always_comb begin
    case (gran)
      GRAN_WORD:  lim = bound[0];
      GRAN_BLOCK: lim = bound[1];
      default:    lim = end_addr;
    endcase
    piece_last  = (lim >= end_addr);
    piece_next  = piece_last ? end_addr : lim;
    span        = piece_next - cur_ext;
    piece_bytes = span[CNT_W-1:0];
  end

  assign unused_span_hi = ^span[ADDR_W:CNT_W];

endmodule

// File: rtl/asplit_seq.sv
module asplit_seq
  import asplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_LG = 6,
  parameter int LG_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bzero_split,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LG_W-1:0]   req_size_lg2,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_priv,
  input  logic              sub_ready,
  input  logic              sub_fail,
  input  logic              rsp_ready,
  input  logic [ADDR_W:0]   piece_next,
  input  logic              piece_last,
  output logic              req_ready,
  output logic              sub_valid,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W:0]   end_addr,
  output gran_e             gran,
  output logic [1:0]        kind,
  output logic [1:0]        priv,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_fault_addr
);

  localparam logic [ADDR_W:0]   ONE   = 1;
  localparam logic [LG_W-1:0]   LG_MX = LG_W'(MAX_LG);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W:0]   end_q, end_d;
  gran_e             gran_q, gran_d;
  acc_kind_e         kind_q;
  logic [1:0]        priv_q;
  logic              fault_q, fault_d;
  fault_cause_e      cause_q, cause_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;

  logic            take_req, step, cur_en, fault_en;
  logic [LG_W-1:0] lg_clamp;
  acc_kind_e       req_kind_e;

  assign req_kind_e = acc_kind_e'(req_kind);
  assign lg_clamp   = (req_size_lg2 > LG_MX) ? LG_MX : req_size_lg2;
  assign take_req   = (state_q == ST_IDLE) && req_valid;
  assign step       = (state_q == ST_ISSUE) && sub_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
      ST_ISSUE: if (sub_ready && (sub_fail || piece_last)) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase

    cur_en = take_req || (step && !sub_fail && !piece_last);
    cur_d  = take_req ? req_addr : piece_next[ADDR_W-1:0];

    end_d = {1'b0, req_addr} + (ONE << lg_clamp);
    if (req_kind_e != KIND_BZERO) gran_d = GRAN_WORD;
    else if (cfg_bzero_split)     gran_d = GRAN_BLOCK;
    else                          gran_d = GRAN_WHOLE;

    fault_en = take_req || (step && sub_fail);
    fault_d  = !take_req;
    faddr_d  = take_req ? '0 : cur_q;
    cause_d  = cause_of(kind_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q  <= '0;
      gran_q <= GRAN_WORD;
      kind_q <= KIND_LOAD;
      priv_q <= '0;
    end else if (take_req) begin
      end_q  <= end_d;
      gran_q <= gran_d;
      kind_q <= req_kind_e;
      priv_q <= req_priv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cause_q <= CAUSE_INSTR;
      faddr_q <= '0;
    end else if (fault_en) begin
      fault_q <= fault_d;
      cause_q <= cause_d;
      faddr_q <= faddr_d;
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign sub_valid      = (state_q == ST_ISSUE);
  assign rsp_valid      = (state_q == ST_RESP);
  assign cur_addr       = cur_q;
  assign end_addr       = end_q;
  assign gran           = gran_q;
  assign kind           = kind_q;
  assign priv           = priv_q;
  assign rsp_fault      = fault_q;
  assign rsp_cause      = cause_q;
  assign rsp_fault_addr = faddr_q;

endmodule

// File: rtl/access_splitter.sv
module access_splitter
  import asplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 32,
  parameter int MAX_LG      = 6,
  parameter int LG_W        = $clog2(MAX_LG + 1),
  parameter int CNT_W       = MAX_LG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bzero_split,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LG_W-1:0]   req_size_lg2,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_priv,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [CNT_W-1:0]  sub_bytes,
  output logic [1:0]        sub_kind,
  output logic [1:0]        sub_priv,
  input  logic              sub_fail,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_fault_addr
);

  logic [1:0]      rst_sync_q;
  logic            srst_n;
  logic [ADDR_W:0] end_addr;
  logic [ADDR_W:0] piece_next;
  logic            piece_last;
  gran_e           gran;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  asplit_seq #(
    .ADDR_W (ADDR_W),
    .MAX_LG (MAX_LG),
    .LG_W   (LG_W)
  ) seq_i (
    .clk             (clk),
    .rst_n           (srst_n),
    .cfg_bzero_split (cfg_bzero_split),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_size_lg2    (req_size_lg2),
    .req_kind        (req_kind),
    .req_priv        (req_priv),
    .sub_ready       (sub_ready),
    .sub_fail        (sub_fail),
    .rsp_ready       (rsp_ready),
    .piece_next      (piece_next),
    .piece_last      (piece_last),
    .req_ready       (req_ready),
    .sub_valid       (sub_valid),
    .rsp_valid       (rsp_valid),
    .cur_addr        (sub_addr),
    .end_addr        (end_addr),
    .gran            (gran),
    .kind            (sub_kind),
    .priv            (sub_priv),
    .rsp_fault       (rsp_fault),
    .rsp_cause       (rsp_cause),
    .rsp_fault_addr  (rsp_fault_addr)
  );

  asplit_piece #(
    .ADDR_W      (ADDR_W),
    .WORD_BYTES  (WORD_BYTES),
    .BLOCK_BYTES (BLOCK_BYTES),
    .CNT_W       (CNT_W)
  ) piece_i (
    .cur_addr    (sub_addr),
    .end_addr    (end_addr),
    .gran        (gran),
    .piece_bytes (sub_bytes),
    .piece_next  (piece_next),
    .piece_last  (piece_last)
  );

endmodule

// File: rtl/asplit_chk.sv
module asplit_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              sub_valid,
  input logic              sub_ready,
  input logic [ADDR_W-1:0] sub_addr,
  input logic [CNT_W-1:0]  sub_bytes,
  input logic [1:0]        sub_kind,
  input logic              sub_fail,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_fault,
  input logic [1:0]        rsp_cause,
  input logic [ADDR_W-1:0] rsp_fault_addr
);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, sub_valid, rsp_valid}));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid || rsp_valid) |-> !req_ready);

  assert_part_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr) && $stable(sub_bytes)));

  assert_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_ready && !sub_fail) |=>
      (!sub_valid || (sub_addr == $past(sub_addr) + ADDR_W'($past(sub_bytes)))));

  assert_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> (sub_bytes != '0));

  assert_in_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_kind != 2'd3) |->
      (int'(sub_addr % ADDR_W'(WORD_BYTES)) + int'(sub_bytes) <= WORD_BYTES));

  assert_stop_on_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && sub_ready && sub_fail) |=>
      (rsp_valid && rsp_fault && rsp_fault_addr == $past(sub_addr)));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_fault) && $stable(rsp_cause) && $stable(rsp_fault_addr)));

  assert_rsp_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

endmodule

bind access_splitter asplit_chk #(
  .ADDR_W     (ADDR_W),
  .WORD_BYTES (WORD_BYTES),
  .CNT_W      (CNT_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .sub_valid      (sub_valid),
  .sub_ready      (sub_ready),
  .sub_addr       (sub_addr),
  .sub_bytes      (sub_bytes),
  .sub_kind       (sub_kind),
  .sub_fail       (sub_fail),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_fault      (rsp_fault),
  .rsp_cause      (rsp_cause),
  .rsp_fault_addr (rsp_fault_addr)
);

// File: tb/access_splitter_tb_top.sv
module access_splitter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bzero_split = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size_lg2 = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_priv = '0;
  logic        sub_valid;
  logic        sub_ready;
  logic [31:0] sub_addr;
  logic [6:0]  sub_bytes;
  logic [1:0]  sub_kind;
  logic [1:0]  sub_priv;
  logic        sub_fail;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_fault_addr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // checker model: a part fails if it spans two 32-byte regions or touches the denied range
  bit          deny_en = 1'b0;
  logic [31:0] deny_lo = '0;
  logic [31:0] deny_hi = '0;
  logic [31:0] last_b;
  assign last_b   = sub_addr + 32'(sub_bytes) - 32'd1;
  assign sub_fail = ((sub_addr >> 5) != (last_b >> 5)) ||
                    (deny_en && sub_addr <= deny_hi && last_b >= deny_lo);

  logic [31:0] log_addr [16];
  logic [6:0]  log_bytes [16];
  logic [1:0]  log_kind [16];
  logic [1:0]  log_priv [16];
  int          log_n = 0;
  bit          stall_en = 1'b0;
  int          stall_ctr = 0;
  int          stable_err = 0;
  bit          prev_hold = 1'b0;
  logic [31:0] prev_addr;
  logic [6:0]  prev_bytes;

  always #2 clk = ~clk;

  access_splitter dut_i (
    .clk (clk), .rst_n (rst_n), .cfg_bzero_split (cfg_bzero_split),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .req_size_lg2 (req_size_lg2), .req_kind (req_kind), .req_priv (req_priv),
    .sub_valid (sub_valid), .sub_ready (sub_ready), .sub_addr (sub_addr),
    .sub_bytes (sub_bytes), .sub_kind (sub_kind), .sub_priv (sub_priv),
    .sub_fail (sub_fail), .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
    .rsp_fault (rsp_fault), .rsp_cause (rsp_cause), .rsp_fault_addr (rsp_fault_addr)
  );

  // part responder and logger
  always @(negedge clk) begin
    stall_ctr++;
    sub_ready = !stall_en || (stall_ctr % 3 == 0);
    #1;
    if (prev_hold && (!sub_valid || sub_addr != prev_addr || sub_bytes != prev_bytes))
      stable_err++;
    prev_hold  = sub_valid && !sub_ready;
    prev_addr  = sub_addr;
    prev_bytes = sub_bytes;
    if (sub_valid && sub_ready && log_n < 16) begin
      log_addr[log_n]  = sub_addr;
      log_bytes[log_n] = sub_bytes;
      log_kind[log_n]  = sub_kind;
      log_priv[log_n]  = sub_priv;
      log_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog (all): actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_access(input logic [31:0] a, input logic [2:0] lg, input logic [1:0] k,
                           input logic [1:0] p, input bit cfg, input int npc,
                           input bit f, input logic [31:0] fa, input logic [1:0] cz,
                           input int rsp_wait, input bit busy_poke, input string tag);
    int w;
    int cur;
    int fin;
    int gsz;
    int nb;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "idle before request", req_ready, 1);
    log_n = 0;
    cfg_bzero_split = cfg;
    req_addr = a; req_size_lg2 = lg; req_kind = k; req_priv = p;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (busy_poke) begin
      for (int i = 0; i < 3; i++) begin
        req_valid = 1'b1; req_addr = 32'h0000_0F00; req_size_lg2 = 3'd3;
        chk(req_ready == 1'b0, "R10", "ready low while busy", req_ready, 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    w = 0;
    while (!rsp_valid && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk(rsp_valid == 1'b1, tag, "response seen", rsp_valid, 1);
    // parts: count, layout, carried kind and privilege
    chk(log_n == npc, f ? "R9" : "R2", "part count", log_n, npc);
    cur = int'(a);
    fin = int'(a) + (1 << lg);
    gsz = (k == 2'd3) ? (cfg ? 32 : 0) : 4;
    for (int i = 0; i < npc && i < log_n; i++) begin
      nb = (gsz == 0) ? fin - cur : gsz - (cur % gsz);
      if (cur + nb > fin) nb = fin - cur;
      chk(log_addr[i] == 32'(cur), tag, "part address", log_addr[i], cur);
      chk(log_bytes[i] == 7'(nb), tag, "part bytes", log_bytes[i], nb);
      chk(log_kind[i] == k && log_priv[i] == p, "R12", "part kind/priv",
          {log_kind[i], log_priv[i]}, {k, p});
      cur += nb;
    end
    chk(rsp_fault == f, f ? "R6" : "R8", "fault flag", rsp_fault, f);
    chk(rsp_fault_addr == fa, f ? "R6" : "R8", "fault address", rsp_fault_addr, fa);
    if (f) chk(rsp_cause == cz, "R7", "fault cause", rsp_cause, cz);
    for (int i = 0; i < rsp_wait; i++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_fault == f && rsp_fault_addr == fa, "R11",
          "response held", {rsp_valid, rsp_fault}, {1'b1, f});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R11", "back to idle", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !sub_valid && !rsp_valid, "R1", "in reset",
        {req_ready, sub_valid, rsp_valid}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !sub_valid && !rsp_valid, "R1", "after reset",
        {req_ready, sub_valid, rsp_valid}, 3'b100);

    // aligned word load: one part (R2)
    do_access(32'h100, 3'd2, 2'd0, 2'd1, 1'b0, 1, 1'b0, 32'h0, 2'd0, 0, 1'b0, "R2");
    // misaligned load straddling a word (R2)
    do_access(32'h103, 3'd2, 2'd0, 2'd0, 1'b0, 2, 1'b0, 32'h0, 2'd0, 0, 1'b0, "R2");
    // single byte (R2)
    do_access(32'h7, 3'd0, 2'd1, 2'd3, 1'b0, 1, 1'b0, 32'h0, 2'd0, 0, 1'b0, "R2");
    // aligned 8-byte store split into words (R3)
    do_access(32'h200, 3'd3, 2'd1, 2'd0, 1'b0, 2, 1'b0, 32'h0, 2'd0, 0, 1'b0, "R3");
    // fetch across a word with a stalling checker (R5)
    stall_en = 1'b1; stable_err = 0;
    do_access(32'h1FE, 3'd2, 2'd2, 2'd3, 1'b0, 2, 1'b0, 32'h0, 2'd0, 0, 1'b0, "R5");
    chk(stable_err == 0, "R5", "part stable while stalled", stable_err, 0);
    stall_en = 1'b0;
    // block zero in halves passes (R4)
    do_access(32'h40, 3'd6, 2'd3, 2'd1, 1'b1, 2, 1'b0, 32'h0, 2'd0, 0, 1'b0, "R4");
    // same block zero as one operation faults (R4, R6)
    do_access(32'h40, 3'd6, 2'd3, 2'd1, 1'b0, 1, 1'b1, 32'h40, 2'd2, 0, 1'b0, "R4");
    // store failing on middle part, first part committed, third never issued (R6, R9)
    deny_en = 1'b1; deny_lo = 32'h304; deny_hi = 32'h307;
    do_access(32'h302, 3'd3, 2'd1, 2'd0, 1'b0, 2, 1'b1, 32'h304, 2'd2, 0, 1'b0, "R9");
    // load failing on first part (R7 load class)
    deny_lo = 32'h400; deny_hi = 32'h403;
    do_access(32'h402, 3'd2, 2'd0, 2'd0, 1'b0, 1, 1'b1, 32'h402, 2'd1, 0, 1'b0, "R7");
    // fetch failing on last part, response held (R7 instruction class, R11)
    deny_lo = 32'h404; deny_hi = 32'h407;
    do_access(32'h402, 3'd2, 2'd2, 2'd2, 1'b0, 2, 1'b1, 32'h404, 2'd0, 3, 1'b0, "R7");
    deny_en = 1'b0;
    // request raised while busy is ignored (R10)
    do_access(32'h103, 3'd2, 2'd0, 2'd1, 1'b0, 2, 1'b0, 32'h0, 2'd0, 2, 1'b1, "R10");
    repeat (3) @(negedge clk);
    chk(!sub_valid && !rsp_valid && log_n == 2, "R10", "no extra work after busy poke",
        log_n, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule